// File: doc/BRIEF.md
# Low-Power Compare Timer

A 16-bit compare timer that counts tick enables from one of four slow time bases. A match against a compare value wraps the counter to zero and raises a sticky flag, which can drive an interrupt. The tick sources are single-cycle enable pulses in the register clock domain. A two-bit select picks one of them, and an optional power-of-two divider can sit between the chosen source and the counter. A bypass bit removes the divider.

Software drives the block through a simple word-wide register port with four addresses: control, scale, compare and count. The count register is read through a snapshot latch: any write to it captures the live count, and reads return the snapshot. The compare register is protected while the timer runs. It accepts a new value only when the timer is stopped or the match flag is pending. That is how a driver may safely retarget the timer from its interrupt handler.

Top module: `lp_cmp_timer`

## Requirements
- R1: Each effective tick advances the count by one, unless a wrap or the priming tick (R3) applies.
- R2: A tick arriving while the count equals the compare value returns the count to zero and sets the match flag in the same cycle. The steady-state period is therefore compare+1 ticks.
- R3: After the run bit goes from 0 to 1, the first effective tick only primes the counter and the count stays 0. Counting starts on the next tick.
- R4: The match flag is control bit 2. Writing 1 to it clears the flag, and writing 0 leaves it unchanged. The flag is sticky, including across clearing of the run bit.
- R5: Any write to address 3 captures the live count into a snapshot register, whatever the data written. Reads of address 3 return the snapshot, which holds until the next such write.
- R6: A write to the compare register (address 2) is taken when run is 0 or the match flag is 1. Otherwise it is ignored.
- R7: With the run bit (control bit 0) at 0, the count and the divider are held at zero.
- R8: The irq output is high exactly when the match flag and the interrupt-enable bit (control bit 1) are both 1.
- R9: Scale bits [6:5] select which bit of tick_src is the tick source. Pulses on the other bits have no effect.
- R10: With the bypass bit (scale bit 4) set, every pulse of the selected source is an effective tick.
- R11: With bypass clear, the prescale value p in scale bits [3:0] makes one effective tick out of every 2^(p+1) source pulses.
- R12: After reset, control and scale read 0, compare reads 0xFFFF and the count snapshot reads 0. The address map is: 0 control, 1 scale, 2 compare, 3 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src | input | 4 | Single-cycle tick enables of the four time bases |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Match interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 4-bit prescale field with the divider present, and four sources. This makes wraps at small compare values, the divide-by-four setting and every source select reachable within a few hundred cycles. The directed cases cover the priming tick, the compare lock, the write-1-to-clear flag and the snapshot hold. Seeded random traffic then mixes pulses on selected and unselected sources, compare writes, flag clears and reconfiguration against a bench model.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   typedef enum logic [1:0] {
      A_CTRL  = 2'd0,
      A_SCALE = 2'd1,
      A_CMP   = 2'd2,
      A_CNT   = 2'd3
   } lpt_addr_e;

   localparam int CTRL_RUN  = 0;
   localparam int CTRL_IE   = 1;
   localparam int CTRL_FLAG = 2;
endpackage

// File: rtl/lpt_tick_div.sv
module lpt_tick_div #(
   parameter int PS_W    = 4,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            tick_in,
   input  logic            bypass,
   input  logic [PS_W-1:0] scale,
   output logic            tick_out
);
   localparam int DIV_W = 1 << PS_W;

   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] term;
         logic [PS_W:0]    shamt;

         assign shamt = {1'b0, scale} + 1'b1;
         assign term  = (DIV_W'(1) << shamt) - DIV_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!run)
               div_q <= '0;
            else if (tick_in && !bypass)
               div_q <= (div_q >= term) ? '0 : div_q + DIV_W'(1);
         end

         assign tick_out = run & tick_in & (bypass | (div_q >= term));

         // R11: the divider restarts after each terminal pulse
         p_div_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick_in && !bypass && div_q == term) |=> (div_q == '0));
      end else begin : g_nodiv
         logic unused_cfg;
         assign unused_cfg = bypass ^ (^scale) ^ clk ^ rst_n;
         assign tick_out   = run & tick_in;
      end
   endgenerate
endmodule

// File: rtl/lpt_count_core.sv
module lpt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);
   logic primed_q;
   logic hit;

   assign hit = run & tick & primed_q & (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         primed_q <= 1'b0;
      end else if (!run) begin
         cnt      <= '0;
         primed_q <= 1'b0;
      end else if (tick) begin
         if (!primed_q)
            primed_q <= 1'b1;
         else if (hit)
            cnt <= '0;
         else
            cnt <= cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (hit)
         flag <= 1'b1;
      else if (flag_clr)
         flag <= 1'b0;
   end

   // R2: a new flag always coincides with a wrap to zero
   p_flag_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == '0));

   // R1: the count only steps by one or returns to zero
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)));

   // R7: a stopped timer leaves the count at zero
   p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer #(
   parameter int CNT_W   = 16,
   parameter int PS_W    = 4,
   parameter int N_SRC   = 4,
   parameter int DATA_W  = 32,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  tick_src,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   import lpt_pkg::*;

   localparam int SEL_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int BYP_BIT = PS_W;
   localparam int SRC_LSB = PS_W + 1;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("lp_cmp_timer: CNT_W out of range");
      end
      if (PS_W < 1 || PS_W > 5 || SRC_LSB + SEL_W > DATA_W) begin : g_bad_ps
         $error("lp_cmp_timer: PS_W out of range");
      end
      if (N_SRC < 2 || N_SRC != (1 << SEL_W)) begin : g_bad_src
         $error("lp_cmp_timer: N_SRC must be a power of two above one");
      end
   endgenerate

   logic             run_q, ie_q, byp_q;
   logic [PS_W-1:0]  ps_q;
   logic [SEL_W-1:0] src_q;
   logic [CNT_W-1:0] cmp_q, latch_q, cnt;
   logic             flag, sel_tick, eff_tick, flag_clr;
   logic             wr_ctrl, wr_scale, wr_cmp, wr_cnt;
   logic             unused_wdata;

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_scale = reg_wr && (reg_addr == A_SCALE);
   assign wr_cmp   = reg_wr && (reg_addr == A_CMP);
   assign wr_cnt   = reg_wr && (reg_addr == A_CNT);
   assign flag_clr = wr_ctrl && reg_wdata[CTRL_FLAG];
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ie_q    <= 1'b0;
         byp_q   <= 1'b0;
         ps_q    <= '0;
         src_q   <= '0;
         cmp_q   <= '1;
         latch_q <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= reg_wdata[CTRL_RUN];
            ie_q  <= reg_wdata[CTRL_IE];
         end
         if (wr_scale) begin
            ps_q  <= reg_wdata[PS_W-1:0];
            byp_q <= reg_wdata[BYP_BIT];
            src_q <= reg_wdata[SRC_LSB +: SEL_W];
         end
         if (wr_cmp && (!run_q || flag))
            cmp_q <= reg_wdata[CNT_W-1:0];
         if (wr_cnt)
            latch_q <= cnt;
      end
   end

   assign sel_tick = tick_src[src_q];

   lpt_tick_div #(.PS_W(PS_W), .HAS_DIV(HAS_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick_in(sel_tick),
      .bypass(byp_q), .scale(ps_q), .tick_out(eff_tick)
   );

   lpt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick(eff_tick),
      .cmp(cmp_q), .flag_clr(flag_clr), .cnt(cnt), .flag(flag)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL: begin
            reg_rdata[CTRL_RUN]  = run_q;
            reg_rdata[CTRL_IE]   = ie_q;
            reg_rdata[CTRL_FLAG] = flag;
         end
         A_SCALE: begin
            reg_rdata[PS_W-1:0]          = ps_q;
            reg_rdata[BYP_BIT]           = byp_q;
            reg_rdata[SRC_LSB +: SEL_W]  = src_q;
         end
         A_CMP:   reg_rdata = DATA_W'(cmp_q);
         default: reg_rdata = DATA_W'(latch_q);
      endcase
   end

   assign irq = flag & ie_q;

   // R6: a locked compare register keeps its value
   p_cmp_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmp && run_q && !flag) |=> $stable(cmp_q));

   // R5: the snapshot changes only on a count-register write
   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> $stable(latch_q));

   // R8: the interrupt never fires while masked
   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !wr_ctrl) |=> !irq);
endmodule

// File: tb/lp_cmp_timer_tb_top.sv
module lp_cmp_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tick_src = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails = 0;

   // bench model
   bit       m_run, m_ie, m_flag, m_primed, m_byp;
   int       m_cnt, m_cmp, m_div, m_ps, m_src;

   always #10ns clk = ~clk;

   lp_cmp_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int div_len(input int ps);
      return 1 << (ps + 1);
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      case (a)
         2'd0: begin
            m_run = d[0]; m_ie = d[1];
            if (d[2]) m_flag = 1'b0;
            if (!m_run) begin m_cnt = 0; m_primed = 1'b0; m_div = 0; end
         end
         2'd1: begin m_ps = int'(d[3:0]); m_byp = d[4]; m_src = int'(d[6:5]); end
         2'd2: if (!m_run || m_flag) m_cmp = int'(d[15:0]);
         default: ;
      endcase
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1ns;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [3:0] mask);
      bit t;
      @(negedge clk);
      tick_src = mask;
      @(negedge clk);
      tick_src = '0;
      t = 1'b0;
      if (m_run && mask[m_src]) begin
         if (m_byp) t = 1'b1;
         else if (m_div == div_len(m_ps) - 1) begin m_div = 0; t = 1'b1; end
         else m_div++;
      end
      if (t) begin
         if (!m_primed) m_primed = 1'b1;
         else if (m_cnt == m_cmp) begin m_cnt = 0; m_flag = 1'b1; end
         else m_cnt++;
      end
   endtask

   task automatic snap_check(input string req);
      logic [31:0] d;
      wr(2'd3, $urandom());
      rd(2'd3, d);
      chk(req, d, 32'(m_cnt));
      rd(2'd0, d);
      chk({req, " flag"}, d, {29'd0, m_flag, m_ie, m_run});
      chk({req, " irq (R8)"}, {31'd0, irq}, {31'd0, m_flag & m_ie});
   endtask

   initial begin
      #(20ns * 150000);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5eed_1234));
      m_run = 0; m_ie = 0; m_flag = 0; m_primed = 0; m_byp = 0;
      m_cnt = 0; m_cmp = 16'hFFFF; m_div = 0; m_ps = 0; m_src = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset values
      rd(2'd0, d); chk("R12 ctrl", d, 0);
      rd(2'd1, d); chk("R12 scale", d, 0);
      rd(2'd2, d); chk("R12 compare", d, 32'hFFFF);
      rd(2'd3, d); chk("R12 snapshot", d, 0);
      chk("R12 irq", {31'd0, irq}, 0);

      // bypass, source 1, compare 3
      wr(2'd1, 32'h30);
      wr(2'd2, 32'd3);
      rd(2'd2, d); chk("R6 compare write while stopped", d, 3);
      wr(2'd0, 32'h3);
      pulse(4'b0010);
      snap_check("R3 priming tick keeps zero");
      repeat (3) pulse(4'b0010);
      snap_check("R1 count after three ticks");
      pulse(4'b1101);
      snap_check("R9 unselected sources ignored");
      pulse(4'b0010);
      snap_check("R2 wrap sets flag");
      chk("R2 irq at wrap", {31'd0, irq}, 1);

      wr(2'd0, 32'h3);
      rd(2'd0, d); chk("R4 write 0 keeps flag", d, 7);
      wr(2'd2, 32'd2);
      rd(2'd2, d); chk("R6 compare accepted with flag set", d, 2);
      wr(2'd0, 32'h7);
      rd(2'd0, d); chk("R4 write 1 clears flag", d, 3);
      chk("R8 irq low after clear", {31'd0, irq}, 0);
      wr(2'd2, 32'd9);
      rd(2'd2, d); chk("R6 locked compare ignores write", d, 2);

      pulse(4'b0010);
      snap_check("R5 snapshot of count 1");
      pulse(4'b0010);
      rd(2'd3, d); chk("R5 snapshot holds without write", d, 1);
      snap_check("R10 bypass count 2");
      pulse(4'b0010);
      snap_check("R2 period of compare+1");

      wr(2'd0, 32'h2);
      snap_check("R7 stop clears count");
      rd(2'd0, d); chk("R4 flag sticky while stopped", d, 6);
      wr(2'd0, 32'h4);

      // divide by four
      wr(2'd1, 32'h21);
      wr(2'd2, 32'd100);
      wr(2'd0, 32'h1);
      repeat (11) pulse(4'b0010);
      snap_check("R11 eleven pulses at divide by four");
      pulse(4'b0010);
      snap_check("R11 twelfth pulse advances");

      // seeded random traffic
      for (int i = 0; i < 400; i++) begin
         int op;
         op = int'($urandom_range(0, 99));
         if (op < 65) pulse(4'($urandom()));
         else if (op < 80) snap_check("R1 random count");
         else if (op < 88) wr(2'd2, 32'($urandom_range(0, 5)));
         else if (op < 93) wr(2'd0, {29'd0, 1'($urandom()), 1'($urandom()), 1'b1});
         else begin
            wr(2'd0, 32'h4);
            wr(2'd2, 32'($urandom_range(0, 5)));
            wr(2'd1, {25'd0, 2'($urandom()), 1'($urandom()), 4'($urandom_range(0, 1))});
            wr(2'd0, {30'd0, 1'($urandom()), 1'b1});
         end
         if (op >= 80 && op < 88) begin
            rd(2'd2, d); chk("R6 random compare", d, 32'(m_cmp));
         end
      end
      snap_check("R2 final state");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule